// File: doc/BRIEF.md
# Dual-Class Interrupt Status Controller

This block collects interrupt events from two sources, a bus-side protocol class and a DMA class, and folds them into one interrupt line. Each event pulse sets a bit in a sticky status register. A per-class enable register masks each status bit before it can reach the interrupt output. Reading a status register returns every pending bit and clears those bits in the same access. The DMA status register also carries a live FIFO-empty flag in its top bit. That flag never raises the interrupt and is not cleared by a read.

Bus-side events that the `FATAL_MASK` parameter marks as fatal need ordering while the block is receiving. If the FIFO still holds data, the event is parked inside the block, and a drain request goes out to the memory side. The event becomes visible status only when the drain completes or the FIFO reports empty. In the send direction, and for every DMA event, the status bit is set at once. The register port also has write-one control bits that emit single-cycle pulses to clear or flush the FIFOs.

Top module: `irq_status_ctl`

## Requirements
- R1: An event pulse on `bus_ev` or `dma_ev` sets the matching status bit at the next clock edge. The bit stays set until its register is read, including while its enable bit is 0.
- R2: A read of address 0 (bus status) or address 2 (DMA status, event bits [6:0]) returns the pending bits on `rd_data` in the same cycle. Those bits read as 0 after that edge.
- R3: An event that arrives in the same cycle as a read that clears its register is kept as pending.
- R4: `irq` is high exactly when some status bit and its enable bit are both 1.
- R5: Bit 7 of the DMA status read (address 2) always equals the `dma_fifo_empty` input. Reading does not clear it, and it never drives `irq`.
- R6: A fatal bus event (a bit set in `FATAL_MASK`, default bits 0 and 1) that arrives with `rx_dir`=1 and `dma_fifo_empty`=0 is held back. The next cycle shows `drain_req`=1, and the bit stays out of bus status.
- R7: A held fatal event moves into bus status at the edge where `drain_done` or `dma_fifo_empty` is 1. `drain_req` falls at that same edge.
- R8: A fatal bus event that arrives with `rx_dir`=0 sets bus status at once, and `drain_req` stays 0.
- R9: DMA events and non-fatal bus events set status at once, in either direction, with no drain request.
- R10: At address 4, writing a 1 to bit 2 gives a one-cycle `dma_fifo_clr` pulse and writing a 1 to bit 3 gives a one-cycle `dma_fifo_flush` pulse. At address 5, writing a 1 to bit 1 gives a one-cycle `bus_fifo_clr` pulse. Both addresses read as 0.
- R11: The bus enable register (address 1) and the DMA enable register (address 3, 7 bits) are writable and read back what was written.
- R12: After reset, all status, enable and held bits are 0, and `irq`, `drain_req` and the three FIFO pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_ev | input | BUS_W | Bus-side event pulses |
| dma_ev | input | DMA_EV_W | DMA event pulses |
| rx_dir | input | 1 | 1 while data flows from the bus toward memory |
| dma_fifo_empty | input | 1 | DMA FIFO holds no data |
| drain_done | input | 1 | Memory side finished draining the FIFO |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on read) |
| addr | input | 3 | Register address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for the addressed register |
| irq | output | 1 | Combined masked interrupt |
| drain_req | output | 1 | A fatal event waits on a FIFO drain |
| dma_fifo_clr | output | 1 | One-cycle DMA FIFO clear pulse |
| dma_fifo_flush | output | 1 | One-cycle DMA FIFO flush pulse |
| bus_fifo_clr | output | 1 | One-cycle bus-side FIFO clear pulse |

## Verification
A status bit that drops on its own, or fails to clear, shows up on the next status read. When that bit is enabled, the error also appears on `irq` one cycle after the event. A held fatal event that is lost or released too early shows up as a wrong `drain_req` level one cycle after the event. It also shows up as a wrong bus status read right after the drain completes. A control pulse that is stuck or too wide differs at the port on the second cycle after the write.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      SEL_BUS_STAT  = 3'd0,
      SEL_BUS_EN    = 3'd1,
      SEL_DMA_STAT  = 3'd2,
      SEL_DMA_EN    = 3'd3,
      SEL_DMA_FCTL  = 3'd4,
      SEL_BUS_FCTL  = 3'd5
   } reg_sel_e;

   // Control bit positions inside the FIFO control registers
   localparam int DMA_CLR_POS   = 2;
   localparam int DMA_FLUSH_POS = 3;
   localparam int BUS_CLR_POS   = 1;

endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_i,
   input  logic         en_we_i,
   input  logic [W-1:0] en_d_i,
   output logic [W-1:0] stat_o,
   output logic [W-1:0] en_o,
   output logic         hit_o
);

   logic [W-1:0] stat_q;
   logic [W-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
      end else begin
         stat_q <= (stat_q & {W{~clr_i}}) | set_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (en_we_i) begin
         en_q <= en_d_i;
      end
   end

   assign stat_o = stat_q;
   assign en_o   = en_q;
   assign hit_o  = |(stat_q & en_q);

endmodule

// File: rtl/irq_drain_gate.sv
module irq_drain_gate #(
   parameter int           W          = 8,
   parameter logic [W-1:0] FATAL_MASK = '0,
   parameter bit           DEFER_EN   = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ev_i,
   input  logic         rx_dir_i,
   input  logic         fifo_empty_i,
   input  logic         drain_done_i,
   output logic [W-1:0] fwd_o,
   output logic         drain_req_o
);

   if (DEFER_EN) begin : g_defer
      logic [W-1:0] hold_q;
      logic [W-1:0] defer;
      logic         release_now;

      assign defer       = rx_dir_i ? (ev_i & FATAL_MASK) : '0;
      assign release_now = drain_done_i | fifo_empty_i;
      assign fwd_o       = (ev_i & ~defer) | ((hold_q | defer) & {W{release_now}});
      assign drain_req_o = |hold_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= '0;
         end else if (release_now) begin
            hold_q <= '0;
         end else begin
            hold_q <= hold_q | defer;
         end
      end
   end else begin : g_pass
      logic unused_in;
      assign unused_in   = rx_dir_i ^ fifo_empty_i ^ drain_done_i ^ clk ^ rst_n;
      assign fwd_o       = ev_i;
      assign drain_req_o = 1'b0;
   end

endmodule

// File: rtl/irq_fifo_ctl.sv
module irq_fifo_ctl
   import irq_status_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [3:1]        ctl_bits,
   output logic              dma_clr_o,
   output logic              dma_flush_o,
   output logic              bus_clr_o
);

   logic dma_hit;
   logic bus_hit;

   assign dma_hit = wr_en && (addr == SEL_DMA_FCTL);
   assign bus_hit = wr_en && (addr == SEL_BUS_FCTL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dma_clr_o   <= 1'b0;
         dma_flush_o <= 1'b0;
         bus_clr_o   <= 1'b0;
      end else begin
         dma_clr_o   <= dma_hit && ctl_bits[DMA_CLR_POS];
         dma_flush_o <= dma_hit && ctl_bits[DMA_FLUSH_POS];
         bus_clr_o   <= bus_hit && ctl_bits[BUS_CLR_POS];
      end
   end

endmodule

// File: rtl/irq_status_ctl.sv
module irq_status_ctl
   import irq_status_pkg::*;
#(
   parameter int               BUS_W      = 8,
   parameter int               DMA_EV_W   = 7,
   parameter int               DATA_W     = 8,
   parameter logic [BUS_W-1:0] FATAL_MASK = 8'h03,
   parameter bit               DEFER_EN   = 1'b1,
   parameter bit               REG_IRQ    = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [BUS_W-1:0]    bus_ev,
   input  logic [DMA_EV_W-1:0] dma_ev,
   input  logic                rx_dir,
   input  logic                dma_fifo_empty,
   input  logic                drain_done,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W-1:0]   rd_data,
   output logic                irq,
   output logic                drain_req,
   output logic                dma_fifo_clr,
   output logic                dma_fifo_flush,
   output logic                bus_fifo_clr
);

   localparam int DMA_RD_W = DMA_EV_W + 1;

   if (DATA_W < 4 || DATA_W < BUS_W || DATA_W < DMA_RD_W) begin : g_bad_width
      $error("irq_status_ctl: DATA_W too narrow for the register map");
   end

   logic [BUS_W-1:0]    bus_set;
   logic [BUS_W-1:0]    bus_stat;
   logic [BUS_W-1:0]    bus_en;
   logic [DMA_EV_W-1:0] dma_stat;
   logic [DMA_EV_W-1:0] dma_en;
   logic                bus_hit;
   logic                dma_hit;
   logic                irq_any;
   logic                bus_rd_clr;
   logic                dma_rd_clr;

   assign bus_rd_clr = rd_en && (addr == SEL_BUS_STAT);
   assign dma_rd_clr = rd_en && (addr == SEL_DMA_STAT);

   irq_drain_gate #(
      .W          (BUS_W),
      .FATAL_MASK (FATAL_MASK),
      .DEFER_EN   (DEFER_EN)
   ) u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .ev_i         (bus_ev),
      .rx_dir_i     (rx_dir),
      .fifo_empty_i (dma_fifo_empty),
      .drain_done_i (drain_done),
      .fwd_o        (bus_set),
      .drain_req_o  (drain_req)
   );

   irq_sticky_bank #(.W(BUS_W)) u_bus_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (bus_set),
      .clr_i   (bus_rd_clr),
      .en_we_i (wr_en && (addr == SEL_BUS_EN)),
      .en_d_i  (wr_data[BUS_W-1:0]),
      .stat_o  (bus_stat),
      .en_o    (bus_en),
      .hit_o   (bus_hit)
   );

   irq_sticky_bank #(.W(DMA_EV_W)) u_dma_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (dma_ev),
      .clr_i   (dma_rd_clr),
      .en_we_i (wr_en && (addr == SEL_DMA_EN)),
      .en_d_i  (wr_data[DMA_EV_W-1:0]),
      .stat_o  (dma_stat),
      .en_o    (dma_en),
      .hit_o   (dma_hit)
   );

   irq_fifo_ctl u_fctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .addr        (addr),
      .ctl_bits    (wr_data[3:1]),
      .dma_clr_o   (dma_fifo_clr),
      .dma_flush_o (dma_fifo_flush),
      .bus_clr_o   (bus_fifo_clr)
   );

   assign irq_any = bus_hit | dma_hit;

   if (REG_IRQ) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_any;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_any;
   end

   always_comb begin
      rd_data = '0;
      case (addr)
         SEL_BUS_STAT: rd_data = DATA_W'(bus_stat);
         SEL_BUS_EN:   rd_data = DATA_W'(bus_en);
         SEL_DMA_STAT: rd_data = DATA_W'({dma_fifo_empty, dma_stat});
         SEL_DMA_EN:   rd_data = DATA_W'(dma_en);
         default:      rd_data = '0;
      endcase
   end

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
   import irq_status_pkg::*;
#(
   parameter int               BUS_W      = 8,
   parameter int               DMA_EV_W   = 7,
   parameter int               DATA_W     = 8,
   parameter logic [BUS_W-1:0] FATAL_MASK = 8'h03
) (
   input logic                clk,
   input logic                rst_n,
   input logic [BUS_W-1:0]    bus_ev,
   input logic [DMA_EV_W-1:0] dma_ev,
   input logic                rx_dir,
   input logic                dma_fifo_empty,
   input logic                drain_done,
   input logic                wr_en,
   input logic                rd_en,
   input logic [ADDR_W-1:0]   addr,
   input logic [DATA_W-1:0]   wr_data,
   input logic [BUS_W-1:0]    bus_stat,
   input logic [BUS_W-1:0]    bus_en,
   input logic [DMA_EV_W-1:0] dma_stat,
   input logic [DMA_EV_W-1:0] dma_en,
   input logic                irq,
   input logic                drain_req,
   input logic                dma_fifo_clr
);

   // R1
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && addr == SEL_BUS_STAT) |=> ((bus_stat & $past(bus_stat)) == $past(bus_stat)));

   // R2
   bus_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == SEL_BUS_STAT && bus_ev == '0 && !drain_req) |=> (bus_stat == '0));

   // R2
   dma_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == SEL_DMA_STAT && dma_ev == '0) |=> (dma_stat == '0));

   // R4
   no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en == '0 && dma_en == '0 && $past(bus_en) == '0 && $past(dma_en) == '0) |-> !irq);

   // R6
   defer_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_dir && (bus_ev & FATAL_MASK) != '0 && !dma_fifo_empty && !drain_done) |=> drain_req);

   // R6
   defer_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drain_req && !dma_fifo_empty && !drain_done) |=> drain_req);

   // R7
   defer_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drain_req && (drain_done || dma_fifo_empty)) |=> !drain_req);

   // R10
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_fifo_clr && !(wr_en && addr == SEL_DMA_FCTL && wr_data[DMA_CLR_POS])) |=> !dma_fifo_clr);

endmodule

bind irq_status_ctl irq_status_chk #(
   .BUS_W      (BUS_W),
   .DMA_EV_W   (DMA_EV_W),
   .DATA_W     (DATA_W),
   .FATAL_MASK (FATAL_MASK)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_ev         (bus_ev),
   .dma_ev         (dma_ev),
   .rx_dir         (rx_dir),
   .dma_fifo_empty (dma_fifo_empty),
   .drain_done     (drain_done),
   .wr_en          (wr_en),
   .rd_en          (rd_en),
   .addr           (addr),
   .wr_data        (wr_data),
   .bus_stat       (bus_stat),
   .bus_en         (bus_en),
   .dma_stat       (dma_stat),
   .dma_en         (dma_en),
   .irq            (irq),
   .drain_req      (drain_req),
   .dma_fifo_clr   (dma_fifo_clr)
);

// File: tb/test_irq_status_ctl.sv
`timescale 1ns/1ps
module test_irq_status_ctl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_ev = '0;
   logic [6:0] dma_ev = '0;
   logic       rx_dir = 1'b0;
   logic       dma_fifo_empty = 1'b1;
   logic       drain_done = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       irq, drain_req, dma_fifo_clr, dma_fifo_flush, bus_fifo_clr;

   int checks = 0;
   int fails  = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   irq_status_ctl i_irq_status_ctl (
      .clk(clk), .rst_n(rst_n), .bus_ev(bus_ev), .dma_ev(dma_ev),
      .rx_dir(rx_dir), .dma_fifo_empty(dma_fifo_empty), .drain_done(drain_done),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .irq(irq), .drain_req(drain_req),
      .dma_fifo_clr(dma_fifo_clr), .dma_fifo_flush(dma_fifo_flush),
      .bus_fifo_clr(bus_fifo_clr)
   );

   always #4 clk = ~clk;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wr_data = d;
      cyc();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
      exp_q.push_back(exp);
      tag_q.push_back(req);
      rd_en = 1'b1; addr = a;
      cyc();
      rd_en = 1'b0;
   endtask

   task automatic bus_pulse(input logic [7:0] v);
      bus_ev = v;
      cyc();
      bus_ev = '0;
   endtask

   // Monitor: compares read data against the scoreboard between edges
   always @(negedge clk) begin
      if (rd_en) begin
         if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: unexpected read, actual %h expected none", rd_data);
         end else begin
            chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
         end
      end
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R12 reset state
      chk("R12 irq", {7'd0, irq}, 8'h00);
      chk("R12 drain_req", {7'd0, drain_req}, 8'h00);
      chk("R12 pulses", {5'd0, dma_fifo_clr, dma_fifo_flush, bus_fifo_clr}, 8'h00);
      rst_n = 1'b1;
      cyc();
      rd(3'd0, 8'h00, "R12 bus status");
      rd(3'd2, 8'h80, "R12/R5 dma status");

      // R1 sticky while disabled, R2 read clears
      bus_pulse(8'h10);
      chk("R4 masked irq", {7'd0, irq}, 8'h00);
      cyc();
      rd(3'd0, 8'h10, "R1 sticky");
      rd(3'd0, 8'h00, "R2 cleared");

      // R11 enables
      wr(3'd1, 8'hF0);
      rd(3'd1, 8'hF0, "R11 bus en");
      wr(3'd3, 8'hFF);
      rd(3'd3, 8'h7F, "R11 dma en");

      // R4 enabled bit drives irq, read drops it
      bus_pulse(8'h20);
      chk("R4 irq on", {7'd0, irq}, 8'h01);
      rd(3'd0, 8'h20, "R2 bus read");
      chk("R4 irq off", {7'd0, irq}, 8'h00);
      bus_pulse(8'h04);
      chk("R4 masked bit", {7'd0, irq}, 8'h00);
      rd(3'd0, 8'h04, "R1 masked latch");

      // R9 DMA immediate, R5 empty bit
      dma_fifo_empty = 1'b0;
      rx_dir = 1'b1;
      dma_ev = 7'h05;
      cyc();
      dma_ev = '0;
      chk("R9 irq", {7'd0, irq}, 8'h01);
      chk("R9 no drain", {7'd0, drain_req}, 8'h00);
      rd(3'd2, 8'h05, "R9 dma status");
      dma_fifo_empty = 1'b1;
      cyc();
      chk("R5 no irq", {7'd0, irq}, 8'h00);
      rd(3'd2, 8'h80, "R5 empty bit");
      rd(3'd2, 8'h80, "R5 not cleared");
      rx_dir = 1'b0;

      // R3 event coincident with clearing read
      bus_pulse(8'h10);
      bus_ev = 8'h40;
      rd(3'd0, 8'h10, "R3 old value");
      bus_ev = '0;
      rd(3'd0, 8'h40, "R3 kept");

      // R6/R7 deferral released by drain_done
      dma_fifo_empty = 1'b0;
      rx_dir = 1'b1;
      bus_pulse(8'h01);
      chk("R6 drain_req", {7'd0, drain_req}, 8'h01);
      rd(3'd0, 8'h00, "R6 hidden");
      chk("R6 still held", {7'd0, drain_req}, 8'h01);
      drain_done = 1'b1;
      cyc();
      drain_done = 1'b0;
      chk("R7 drain_req low", {7'd0, drain_req}, 8'h00);
      rd(3'd0, 8'h01, "R7 released");

      // R7 release by FIFO empty
      bus_pulse(8'h02);
      chk("R6 drain_req 2", {7'd0, drain_req}, 8'h01);
      dma_fifo_empty = 1'b1;
      cyc();
      chk("R7 empty release", {7'd0, drain_req}, 8'h00);
      rd(3'd0, 8'h02, "R7 via empty");

      // R9 non-fatal in receive direction
      dma_fifo_empty = 1'b0;
      bus_pulse(8'h08);
      chk("R9 nonfatal drain", {7'd0, drain_req}, 8'h00);
      rd(3'd0, 8'h08, "R9 nonfatal");

      // R8 fatal while sending
      rx_dir = 1'b0;
      bus_pulse(8'h01);
      chk("R8 no drain", {7'd0, drain_req}, 8'h00);
      rd(3'd0, 8'h01, "R8 immediate");
      dma_fifo_empty = 1'b1;

      // R10 FIFO control pulses
      wr(3'd4, 8'h04);
      chk("R10 dma clr", {6'd0, dma_fifo_clr, dma_fifo_flush}, 8'h02);
      cyc();
      chk("R10 dma clr end", {7'd0, dma_fifo_clr}, 8'h00);
      wr(3'd4, 8'h08);
      chk("R10 dma flush", {6'd0, dma_fifo_clr, dma_fifo_flush}, 8'h01);
      cyc();
      chk("R10 flush end", {7'd0, dma_fifo_flush}, 8'h00);
      wr(3'd5, 8'h02);
      chk("R10 bus clr", {7'd0, bus_fifo_clr}, 8'h01);
      cyc();
      chk("R10 bus clr end", {7'd0, bus_fifo_clr}, 8'h00);
      rd(3'd4, 8'h00, "R10 readback dma");
      rd(3'd5, 8'h00, "R10 readback bus");

      cyc();
      chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
      finish_run();
   end

endmodule